// File: doc/BRIEF.md
# Differential Pulse Symbol Classifier

This block sits behind a pair of window comparators watching a differential line. One comparator output is high while the line sits above the positive threshold. The other is high while the line sits below the negative threshold. Both outputs reach the block without any relation to its clock, so they are brought into the system clock domain first. The block then looks for two-half pulses. A positive half followed by a negative half is a +1 symbol. A negative half followed by a positive half is a -1 symbol.

Each accepted pulse is sorted by the length of its first half. A long first half marks a chip-select event and a short first half marks a data bit. The block gives each class its own minimum half width and its own limit on the quiet time allowed before the inversion. All four limits come in on configuration inputs, and `cfg_long_min` must be larger than `cfg_short_min`.

The result is a one-cycle symbol strobe that carries the pulse polarity and its class. The strobe fires at a fixed delay after the inversion is first sampled. A symbol is a single event on the wire and cannot be held back, so the output has a valid signal but no ready. A consumer must take every strobe in the cycle it appears.

Top module: `diffpulse_classifier`

## Requirements
- R1: While reset is held, and in the cycles after reset until a pulse is accepted, `sym_valid_o` is low.
- R2: Both comparator inputs pass through a two-flop synchroniser. If the opposite-polarity input is first sampled high at rising edge k, the strobe is high in the cycle that follows edge k+2.
- R3: `sym_pos_o` is 1 for a pulse whose first half is on `cmp_hi_i` (+1). It is 0 for a pulse whose first half is on `cmp_lo_i` (-1).
- R4: If the first half is held for at least `cfg_long_min` sampled cycles, the symbol is long (`sym_long_o` = 1).
- R5: If the first half is held for at least `cfg_short_min` but fewer than `cfg_long_min` sampled cycles, the symbol is short (`sym_long_o` = 0).
- R6: If the first half is held for fewer than `cfg_short_min` cycles, it is discarded and no strobe follows.
- R7: The inversion may follow g sampled cycles in which neither input is high. The pulse is accepted only when g is at most the limit for its class (`cfg_long_inv` or `cfg_short_inv`). Otherwise the candidate is dropped.
- R8: The candidate is dropped with no strobe in two cases: both inputs are sampled high while a candidate is open, or the first-half input returns during the quiet gap.
- R9: The strobe lasts one cycle. After a symbol, nothing new is recognised until both synchronised inputs have been low together, so a held second half never yields a second symbol.
- R10: `sym_pos_o` and `sym_long_o` are 0 whenever `sym_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 1 | Comparator output: line above the positive threshold (asynchronous) |
| cmp_lo_i | input | 1 | Comparator output: line below the negative threshold (asynchronous) |
| cfg_long_min | input | CNT_W | Minimum first-half width for a long pulse, in cycles |
| cfg_short_min | input | CNT_W | Minimum first-half width for a short pulse, in cycles |
| cfg_long_inv | input | CNT_W | Maximum quiet cycles before the inversion, long class |
| cfg_short_inv | input | CNT_W | Maximum quiet cycles before the inversion, short class |
| sym_valid_o | output | 1 | One-cycle symbol strobe |
| sym_pos_o | output | 1 | 1 for +1, 0 for -1; valid with the strobe |
| sym_long_o | output | 1 | 1 for long, 0 for short; valid with the strobe |

## Verification
Pulses of both polarities are driven with first halves set at each class boundary and one cycle to either side. This separates the long class, the short class and the discard case. Quiet gaps set at the window limit and one past it show which class's limit is applied. Two further patterns must leave no symbol: a conflict with both inputs high, and the first-half input returning during the gap. A second half held for many cycles shows that the classifier does not re-arm. A reference model compares the strobe and its fields on every cycle, which pins the three-edge latency.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_GAP   = 2'd2,
    ST_HOLD  = 2'd3
  } dpc_state_e;

  typedef struct packed {
    logic valid;
    logic pos;
    logic is_long;
  } dpc_sym_t;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/dpc_class.sv
module dpc_class #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] long_min_i,
  input  logic [CNT_W-1:0] short_min_i,
  input  logic [CNT_W-1:0] long_inv_i,
  input  logic [CNT_W-1:0] short_inv_i,
  input  logic             sel_long_i,
  output logic             meets_long_o,
  output logic             meets_short_o,
  output logic [CNT_W-1:0] inv_lim_o
);
  always_comb begin
    meets_long_o  = (len_i >= long_min_i);
    meets_short_o = (len_i >= short_min_i);
    inv_lim_o     = sel_long_i ? long_inv_i : short_inv_i;
  end
endmodule

// File: rtl/dpc_fsm.sv
module dpc_fsm
  import dpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_hi_i,
  input  logic             s_lo_i,
  input  logic [CNT_W-1:0] long_min_i,
  input  logic [CNT_W-1:0] short_min_i,
  input  logic [CNT_W-1:0] long_inv_i,
  input  logic [CNT_W-1:0] short_inv_i,
  output dpc_sym_t         sym_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  dpc_state_e       st_q, st_d;
  logic             pol_q, pol_d;
  logic             long_q, long_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  dpc_sym_t         sym_q, sym_d;

  logic             own, opp, both;
  logic             sel_long, meets_long, meets_short;
  logic [CNT_W-1:0] inv_lim;

  assign sel_long = (st_q == ST_FIRST) ? meets_long : long_q;

  dpc_class #(.CNT_W(CNT_W)) u_class (
    .len_i        (len_q),
    .long_min_i   (long_min_i),
    .short_min_i  (short_min_i),
    .long_inv_i   (long_inv_i),
    .short_inv_i  (short_inv_i),
    .sel_long_i   (sel_long),
    .meets_long_o (meets_long),
    .meets_short_o(meets_short),
    .inv_lim_o    (inv_lim)
  );

  always_comb begin
    own  = pol_q ? s_hi_i : s_lo_i;
    opp  = pol_q ? s_lo_i : s_hi_i;
    both = s_hi_i & s_lo_i;

    st_d   = st_q;
    pol_d  = pol_q;
    long_d = long_q;
    len_d  = len_q;
    gap_d  = gap_q;
    sym_d  = '0;

    unique case (st_q)
      ST_IDLE: begin
        if (s_hi_i ^ s_lo_i) begin
          st_d  = ST_FIRST;
          pol_d = s_hi_i;
          len_d = CNT_ONE;
        end
      end
      ST_FIRST: begin
        if (both) begin
          st_d = ST_IDLE;
        end else if (opp) begin
          if (meets_short) begin
            sym_d = '{valid: 1'b1, pos: pol_q, is_long: meets_long};
            st_d  = ST_HOLD;
          end else begin
            st_d = ST_IDLE;
          end
        end else if (own) begin
          if (len_q != CNT_MAX) len_d = len_q + CNT_ONE;
        end else begin
          long_d = meets_long;
          gap_d  = CNT_ONE;
          st_d   = (meets_short && inv_lim != '0) ? ST_GAP : ST_IDLE;
        end
      end
      ST_GAP: begin
        if (both || own) begin
          st_d = ST_IDLE;
        end else if (opp) begin
          sym_d = '{valid: 1'b1, pos: pol_q, is_long: long_q};
          st_d  = ST_HOLD;
        end else if (gap_q >= inv_lim) begin
          st_d = ST_IDLE;
        end else begin
          gap_d = gap_q + CNT_ONE;
        end
      end
      ST_HOLD: begin
        if (!s_hi_i && !s_lo_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pol_q  <= 1'b0;
      long_q <= 1'b0;
      len_q  <= '0;
      gap_q  <= '0;
      sym_q  <= '0;
    end else begin
      st_q   <= st_d;
      pol_q  <= pol_d;
      long_q <= long_d;
      len_q  <= len_d;
      gap_q  <= gap_d;
      sym_q  <= sym_d;
    end
  end

  assign sym_o = sym_q;
endmodule

// File: rtl/diffpulse_classifier.sv
module diffpulse_classifier
  import dpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_hi_i,
  input  logic             cmp_lo_i,
  input  logic [CNT_W-1:0] cfg_long_min,
  input  logic [CNT_W-1:0] cfg_short_min,
  input  logic [CNT_W-1:0] cfg_long_inv,
  input  logic [CNT_W-1:0] cfg_short_inv,
  output logic             sym_valid_o,
  output logic             sym_pos_o,
  output logic             sym_long_o
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] cmp_sync;
  dpc_sym_t   sym;

  dpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({cmp_hi_i, cmp_lo_i}),
    .sync_o (cmp_sync)
  );

  dpc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_hi_i     (cmp_sync[1]),
    .s_lo_i     (cmp_sync[0]),
    .long_min_i (cfg_long_min),
    .short_min_i(cfg_short_min),
    .long_inv_i (cfg_long_inv),
    .short_inv_i(cfg_short_inv),
    .sym_o      (sym)
  );

  assign sym_valid_o = sym.valid;
  assign sym_pos_o   = sym.pos;
  assign sym_long_o  = sym.is_long;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker (
  input logic clk,
  input logic rst_n,
  input logic cmp_hi_i,
  input logic cmp_lo_i,
  input logic sym_valid_o,
  input logic sym_pos_o,
  input logic sym_long_o
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o); // R9

  AST_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid_o |-> (!sym_pos_o && !sym_long_o)); // R10

  AST_POS_INVERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && sym_pos_o) |-> $past(cmp_lo_i, 3)); // R2

  AST_NEG_INVERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_pos_o) |-> $past(cmp_hi_i, 3)); // R3

  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> !($past(cmp_hi_i, 3) && $past(cmp_lo_i, 3))); // R8
endmodule

bind diffpulse_classifier dpc_checker u_dpc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_hi_i   (cmp_hi_i),
  .cmp_lo_i   (cmp_lo_i),
  .sym_valid_o(sym_valid_o),
  .sym_pos_o  (sym_pos_o),
  .sym_long_o (sym_long_o)
);

// File: tb/tb_diffpulse_classifier.sv
module tb_diffpulse_classifier;
  localparam int CNT_W = 8;
  localparam int LMIN = 12;
  localparam int SMIN = 4;
  localparam int LINV = 6;
  localparam int SINV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0;
  logic lo = 1'b0;
  logic sv, sp, sl;

  always #5 clk = ~clk;

  diffpulse_classifier #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi_i(hi), .cmp_lo_i(lo),
    .cfg_long_min(CNT_W'(LMIN)), .cfg_short_min(CNT_W'(SMIN)),
    .cfg_long_inv(CNT_W'(LINV)), .cfg_short_inv(CNT_W'(SINV)),
    .sym_valid_o(sv), .sym_pos_o(sp), .sym_long_o(sl)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  bit [1:0] hist[$];
  int ph = 0, mlen = 0, mgap = 0;
  bit mpol = 0, mlong = 0;
  bit ev = 0, ep = 0, el = 0;

  always @(posedge clk) begin
    bit h, l, own, opp;
    int lim;
    cyc <= cyc + 1;
    ev = 0; ep = 0; el = 0;
    if (!rst_n) begin
      hist.delete(); ph = 0;
    end else begin
      hist.push_back({hi, lo});
      h = 0; l = 0;
      if (hist.size() == 3) begin
        bit [1:0] s;
        s = hist.pop_front();
        h = s[1]; l = s[0];
      end
      own = mpol ? h : l;
      opp = mpol ? l : h;
      case (ph)
        0: if (h != l) begin ph = 1; mpol = h; mlen = 1; end
        1: begin
          if (h && l) ph = 0;
          else if (opp) begin
            if (mlen >= SMIN) begin ev = 1; ep = mpol; el = (mlen >= LMIN); ph = 3; end
            else ph = 0;
          end else if (own) mlen++;
          else begin
            mlong = (mlen >= LMIN);
            lim = mlong ? LINV : SINV;
            mgap = 1;
            ph = (mlen >= SMIN && mgap <= lim) ? 2 : 0;
          end
        end
        2: begin
          lim = mlong ? LINV : SINV;
          if ((h && l) || own) ph = 0;
          else if (opp) begin ev = 1; ep = mpol; el = mlong; ph = 3; end
          else begin mgap++; if (mgap > lim) ph = 0; end
        end
        default: if (!h && !l) ph = 0;
      endcase
    end
  end

  int sym_cnt = 0, last_cyc = 0;
  bit last_pos = 0, last_long = 0;

  always @(negedge clk) begin
    checks++;
    if (sv !== ev || sp !== ep || sl !== el) begin
      fails++;
      $display("FAIL %s (R10 fields) cycle %0d: got v=%b p=%b l=%b expected v=%b p=%b l=%b",
               cur_req, cyc, sv, sp, sl, ev, ep, el);
    end
    if (sv === 1'b1) begin
      sym_cnt++; last_cyc = cyc; last_pos = sp; last_long = sl;
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit h, bit l, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hi = h; lo = l;
    end
  endtask

  int inv_cyc = 0;

  task automatic pulse(bit pos, int h1, int gap, int h2);
    drive(pos, !pos, h1);
    drive(0, 0, gap);
    @(negedge clk); hi = !pos; lo = pos; inv_cyc = cyc;
    drive(!pos, pos, h2 - 1);
    drive(0, 0, 10);
  endtask

  task automatic expect_sym(string req, bit pos, int h1, int gap, int h2,
                            int n_exp, bit pos_exp, bit long_exp);
    cur_req = req;
    sym_cnt = 0;
    pulse(pos, h1, gap, h2);
    chk(req, sym_cnt, n_exp);
    if (n_exp == 1 && sym_cnt == 1) begin
      chk(req, int'(last_pos), int'(pos_exp));
      chk(req, int'(last_long), int'(long_exp));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (sv !== 1'b0) begin fails++; $display("FAIL R1: valid in reset got %b expected 0", sv); end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", sym_cnt, 0);

    // R4 / R3: long +1, direct inversion, check latency R2
    expect_sym("R4", 1, 15, 0, 4, 1, 1, 1);
    chk("R2", last_cyc, inv_cyc + 3);
    // R4 boundary, -1, gap inside long window
    expect_sym("R4", 0, LMIN, 2, 4, 1, 0, 1);
    expect_sym("R3", 0, 20, 0, 3, 1, 0, 1);
    chk("R2", last_cyc, inv_cyc + 3);
    // R5 short class boundaries
    expect_sym("R5", 1, SMIN, 0, 3, 1, 1, 0);
    expect_sym("R5", 0, LMIN - 1, 1, 3, 1, 0, 0);
    // R6 too short
    expect_sym("R6", 1, SMIN - 1, 0, 3, 0, 0, 0);
    expect_sym("R6", 0, 1, 1, 3, 0, 0, 0);
    // R7 windows
    expect_sym("R7", 1, 6, SINV, 3, 1, 1, 0);
    expect_sym("R7", 1, 6, SINV + 1, 3, 0, 0, 0);
    expect_sym("R7", 0, 14, LINV, 3, 1, 0, 1);
    expect_sym("R7", 0, 14, LINV + 1, 3, 0, 0, 0);
    // R8 conflict during first half
    cur_req = "R8"; sym_cnt = 0;
    drive(1, 0, 5); drive(1, 1, 1); drive(0, 1, 5); drive(0, 0, 12);
    chk("R8", sym_cnt, 0);
    // R8 first-half input returns during gap
    sym_cnt = 0;
    drive(1, 0, 6); drive(0, 0, 1); drive(1, 0, 1); drive(0, 1, 4); drive(0, 0, 12);
    chk("R8", sym_cnt, 0);
    // R9 held second half gives one symbol only
    expect_sym("R9", 1, 6, 0, 25, 1, 1, 0);
    // R9 back-to-back after release
    cur_req = "R9"; sym_cnt = 0;
    pulse(0, 5, 0, 3);
    pulse(1, 13, 0, 3);
    chk("R9", sym_cnt, 2);
    chk("R9", int'(last_long), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule